// File: doc/BRIEF.md
# Video Command Stream Expander

This block turns a compact stream of 32-bit commands into the 30-bit symbol words for three DVI lanes. The downstream serializer asks for one word per output slot with a pop strobe. A raw-repeat command names a count, and the word that follows it in the command stream is emitted that many times. This is how sync and blanking periods are described. A pixel command names a count and draws that many 24-bit pixels from a separate pixel stream. Each 8-bit lane of a pixel passes through a TMDS encoder that keeps its own running disparity. Any other opcode is consumed and emits nothing.

Line and frame timing comes entirely from the command list. A line is a few raw runs for the porches and sync, then one pixel run. No horizontal or vertical counter exists in the block. Command and pixel inputs use valid/ready handshakes. The output word is registered and changes only in the cycle after a pop. A pop that finds no word ready keeps the previous word on the lanes and sets a sticky underflow flag.

Ending a run and taking up the next command costs a few cycles: one for each command word and one for the data word of a raw-repeat. The serializer's pop spacing must cover these cycles.

Top module: `vid_cmd_expander`

## Requirements
- R1: After reset, `out_word` holds the idle blanking word. That word has the control symbol for vsync=1, hsync=1 (10'b1010101011) in bits 9:0, and the control symbol 00 (10'b1101010100) in bits 19:10 and bits 29:20. After reset, `underflow` is 0, `cmd_ready` is 1 and `pix_ready` is 0.
- R2: The opcode is taken from command bits 31:28: 4'h1 is raw-repeat and 4'h2 is pixel. The count is taken from bits 11:0. Any other opcode is consumed in one cycle and produces no output word.
- R3: After a raw-repeat command with count N>0, the next command-stream word is consumed as data. Its bits 29:0 then appear on `out_word` for the next N pops, one pop per word.
- R4: A raw-repeat with count 0 still consumes its data word but emits no output word.
- R5: A pixel command with count N>0 consumes exactly N pixels, one on each pop. Each pixel is TMDS-encoded with a running disparity kept per lane. Pixel bits 7:0 go to lane 0 (`out_word` bits 9:0), bits 15:8 to lane 1 (bits 19:10) and bits 23:16 to lane 2 (bits 29:20).
- R6: Every emitted raw word clears the running disparity of all three lanes to zero.
- R7: A pixel command with count 0 consumes no pixel and emits no output word.
- R8: A pop is starved when the block is between runs, or when it is in a pixel run with no pixel valid. A starved pop leaves `out_word` unchanged and sets `underflow`, which stays set until reset.
- R9: `out_word` changes only on the clock edge of a pop and holds its value between pops.
- R10: `pix_ready` is high only in a cycle that is both inside a pixel run and has a pop. `cmd_ready` is high only outside raw and pixel runs. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word available |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| cmd_data | input | 32 | Command or raw data word |
| pix_valid | input | 1 | Pixel available |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| pix_data | input | 24 | Three 8-bit lane values of one pixel |
| out_pop | input | 1 | Serializer requests the next output word |
| out_word | output | 30 | Three 10-bit lane symbols |
| underflow | output | 1 | Sticky flag: a pop found no word ready |

## Verification
The embedded properties check the following on every cycle:
- `out_word` holds still without a pop, and a starved pop holds it and raises `underflow` for good.
- A pop inside a raw run delivers the latched data word and zeroes every lane's disparity.
- Runs never start with a zero count, and unknown opcodes leave the block waiting for a command.
- The pixel and command handshakes never overlap.

Only the bench scenarios can show several other properties. These include the exact TMDS symbols and their disparity history across long random pixel runs. They also include the ordering of mixed raw and pixel runs, with unknown and zero-count commands in between. Finally, they show that zero-count and unknown commands emit no word, seen as the underflow on a pop after the last expected word.

// File: rtl/vid_cmd_expander.sv
module vid_cmd_expander #(
  parameter int         CNT_W  = 12,
  parameter logic [3:0] OP_RAW = 4'h1,
  parameter logic [3:0] OP_PIX = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_data,
  input  logic        pix_valid,
  output logic        pix_ready,
  input  logic [23:0] pix_data,
  input  logic        out_pop,
  output logic [29:0] out_word,
  output logic        underflow
);

  localparam int LANES  = 3;
  localparam int SYM_W  = 10;
  localparam int DISP_W = 6;
  localparam logic [SYM_W-1:0] CTL00 = 10'b1101010100;
  localparam logic [SYM_W-1:0] CTL11 = 10'b1010101011;
  localparam logic [LANES*SYM_W-1:0] IDLE_WORD = {CTL00, CTL00, CTL11};

  typedef enum logic [1:0] {S_CMD, S_DATA, S_RAW, S_PIX} st_t;

  st_t                      st;
  logic [CNT_W-1:0]         left;
  logic [29:0]              raw_q;
  logic signed [DISP_W-1:0] disp [LANES];
  logic signed [DISP_W-1:0] disp_n [LANES];
  logic [SYM_W-1:0]         sym [LANES];

  wire [3:0]       op     = cmd_data[31:28];
  wire [CNT_W-1:0] cnt_in = cmd_data[CNT_W-1:0];

  assign cmd_ready = (st == S_CMD) || (st == S_DATA);
  assign pix_ready = (st == S_PIX) && out_pop;

  wire pix_fire = pix_valid && pix_ready;
  wire produce  = out_pop && ((st == S_RAW) || pix_fire);

  function automatic logic [DISP_W+SYM_W-1:0] tmds_step(
    input logic [7:0] d,
    input logic signed [DISP_W-1:0] cnt
  );
    logic [8:0]               qm;
    logic [3:0]               n1d, n1q;
    logic                     use_xnor;
    logic signed [DISP_W-1:0] bal, nc;
    logic [SYM_W-1:0]         s;
    n1d      = 4'($countones(d));
    use_xnor = (n1d > 4'd4) || (n1d == 4'd4 && !d[0]);
    qm[0]    = d[0];
    for (int i = 1; i < 8; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[8] = ~use_xnor;
    n1q   = 4'($countones(qm[7:0]));
    bal   = $signed({1'b0, n1q, 1'b0}) - 6'sd8;
    if (cnt == 0 || bal == 0) begin
      s  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      nc = qm[8] ? cnt + bal : cnt - bal;
    end else if (cnt[DISP_W-1] == bal[DISP_W-1]) begin
      s  = {1'b1, qm[8], ~qm[7:0]};
      nc = cnt + (qm[8] ? 6'sd2 : 6'sd0) - bal;
    end else begin
      s  = {1'b0, qm[8], qm[7:0]};
      nc = cnt + bal - (qm[8] ? 6'sd0 : 6'sd2);
    end
    return {nc, s};
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++)
      {disp_n[l], sym[l]} = tmds_step(pix_data[8*l +: 8], disp[l]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CMD;
      left      <= '0;
      raw_q     <= IDLE_WORD;
      out_word  <= IDLE_WORD;
      underflow <= 1'b0;
      for (int l = 0; l < LANES; l++) disp[l] <= '0;
    end else begin
      if (out_pop && !produce) underflow <= 1'b1;
      case (st)
        S_CMD: if (cmd_valid) begin
          if (op == OP_RAW) begin
            left <= cnt_in;
            st   <= S_DATA;
          end else if (op == OP_PIX && cnt_in != '0) begin
            left <= cnt_in;
            st   <= S_PIX;
          end
        end
        S_DATA: if (cmd_valid) begin
          raw_q <= cmd_data[29:0];
          st    <= (left == '0) ? S_CMD : S_RAW;
        end
        S_RAW: if (out_pop) begin
          out_word <= raw_q;
          for (int l = 0; l < LANES; l++) disp[l] <= '0;
          left <= left - 1'b1;
          if (left == CNT_W'(1)) st <= S_CMD;
        end
        S_PIX: if (pix_fire) begin
          out_word <= {sym[2], sym[1], sym[0]};
          for (int l = 0; l < LANES; l++) disp[l] <= disp_n[l];
          left <= left - 1'b1;
          if (left == CNT_W'(1)) st <= S_CMD;
        end
        default: st <= S_CMD;
      endcase
    end
  end

  AST_STARVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop && !produce |=> $stable(out_word) && underflow); // R8
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R8
  AST_QUIET_WITHOUT_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !out_pop |=> $stable(out_word)); // R9
  AST_RAW_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop && st == S_RAW |=> out_word == $past(raw_q)); // R3
  AST_RAW_DISP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop && st == S_RAW |=> disp[0] == 0 && disp[1] == 0 && disp[2] == 0); // R6
  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAW || st == S_PIX) |-> left != '0); // R7
  AST_UNKNOWN_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CMD && cmd_valid && op != OP_RAW && op != OP_PIX |=> st == S_CMD); // R2
  AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ready && cmd_ready) && (!pix_ready || out_pop)); // R10

endmodule

// File: tb/vid_cmd_expander_tb.sv
module vid_cmd_expander_tb_top;

  localparam logic [29:0] IDLE_W = {10'b1101010100, 10'b1101010100, 10'b1010101011};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid, cmd_ready, pix_valid, pix_ready;
  logic [31:0] cmd_data;
  logic [23:0] pix_data;
  logic        out_pop = 1'b0;
  logic [29:0] out_word;
  logic        underflow;

  bit [31:0] cmd_mem [0:2047];
  bit [23:0] pix_mem [0:2047];
  bit [29:0] exp_mem [0:2047];
  string     exp_tag [0:2047];
  int ncmd, npix, nexp;
  int cidx, pidx;
  bit pix_hold;
  int mdisp [3];
  bit after_raw;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  assign cmd_valid = rst_n && (cidx < ncmd);
  assign cmd_data  = (cidx < ncmd) ? cmd_mem[cidx] : 32'h0;
  assign pix_valid = rst_n && (pidx < npix) && !pix_hold;
  assign pix_data  = (pidx < npix) ? pix_mem[pidx] : 24'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cidx <= 0;
      pidx <= 0;
    end else begin
      if (cmd_valid && cmd_ready) cidx <= cidx + 1;
      if (pix_valid && pix_ready) pidx <= pidx + 1;
    end
  end

  vid_cmd_expander dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_pop(out_pop), .out_word(out_word), .underflow(underflow)
  );

  function automatic logic [9:0] tm_enc(input logic [7:0] d, input int lane);
    int ones = 0, n1 = 0, bal;
    bit xn, q8;
    logic [7:0] q;
    logic [9:0] r;
    for (int i = 0; i < 8; i++) ones += d[i];
    xn = (ones > 4) || (ones == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = xn ? !(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q8 = !xn;
    for (int i = 0; i < 8; i++) n1 += q[i];
    bal = 2 * n1 - 8;
    if (mdisp[lane] == 0 || bal == 0) begin
      r = {!q8, q8, q8 ? q : ~q};
      mdisp[lane] += q8 ? bal : -bal;
    end else if ((mdisp[lane] > 0 && bal > 0) || (mdisp[lane] < 0 && bal < 0)) begin
      r = {1'b1, q8, ~q};
      mdisp[lane] += 2 * q8 - bal;
    end else begin
      r = {1'b0, q8, q};
      mdisp[lane] += bal - 2 * (!q8);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    ncmd = 0; npix = 0; nexp = 0; pix_hold = 0; after_raw = 0;
    for (int l = 0; l < 3; l++) mdisp[l] = 0;
  endtask

  task automatic add_cmd(input logic [3:0] op, input int cnt);
    cmd_mem[ncmd] = {op, 16'h0, 12'(cnt)};
    ncmd++;
  endtask

  task automatic add_raw(input int cnt, input logic [29:0] w);
    add_cmd(4'h1, cnt);
    cmd_mem[ncmd] = {2'b10, w};
    ncmd++;
    for (int k = 0; k < cnt; k++) begin
      exp_mem[nexp] = w; exp_tag[nexp] = "R3"; nexp++;
      for (int l = 0; l < 3; l++) mdisp[l] = 0;
      after_raw = 1;
    end
  endtask

  task automatic add_pix(input int cnt);
    logic [23:0] p;
    add_cmd(4'h2, cnt);
    for (int k = 0; k < cnt; k++) begin
      p = 24'($urandom);
      pix_mem[npix] = p; npix++;
      exp_mem[nexp] = {tm_enc(p[23:16], 2), tm_enc(p[15:8], 1), tm_enc(p[7:0], 0)};
      exp_tag[nexp] = after_raw ? "R6" : "R5";
      after_raw = 0;
      nexp++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    out_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop_once();
    chk(pix_ready == 1'b0, "R10", 32'(pix_ready), 32'd0);
    out_pop = 1'b1;
    @(negedge clk);
    out_pop = 1'b0;
  endtask

  task automatic run_expected();
    for (int k = 0; k < nexp; k++) begin
      repeat (7) @(negedge clk);
      pop_once();
      chk(out_word == exp_mem[k], exp_tag[k], 32'(out_word), 32'(exp_mem[k]));
      if (k % 4 == 0) begin
        repeat (3) @(negedge clk);
        chk(out_word == exp_mem[k], "R9", 32'(out_word), 32'(exp_mem[k]));
      end
    end
    repeat (8) @(negedge clk);
    chk(underflow == 1'b0, "R8", 32'(underflow), 32'd0);
    chk(cidx == ncmd, "R2", 32'(cidx), 32'(ncmd));
    chk(pidx == npix, "R7", 32'(pidx), 32'(npix));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_prog();
    do_reset();
    chk(out_word == IDLE_W, "R1", 32'(out_word), 32'(IDLE_W));
    chk(underflow == 1'b0, "R1", 32'(underflow), 32'd0);
    chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
    chk(pix_ready == 1'b0, "R1", 32'(pix_ready), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pop_once();
    chk(out_word == IDLE_W, "R8", 32'(out_word), 32'(IDLE_W));
    chk(underflow == 1'b1, "R8", 32'(underflow), 32'd1);
    repeat (3) @(negedge clk);
    chk(underflow == 1'b1, "R8", 32'(underflow), 32'd1);

    do_reset();
    clear_prog();
    add_cmd(4'hF, 0);
    add_raw(3, 30'h0ABC_1234);
    add_raw(0, 30'h1111_2222);
    add_pix(0);
    add_pix(6);
    add_raw(2, 30'h2AAA_5555);
    add_pix(5);
    add_cmd(4'h7, 5);
    add_raw(1, IDLE_W);
    rst_n = 1'b1;
    run_expected();
    pop_once();
    chk(underflow == 1'b1, "R4", 32'(underflow), 32'd1);
    chk(out_word == IDLE_W, "R8", 32'(out_word), 32'(IDLE_W));

    do_reset();
    clear_prog();
    for (int s = 0; s < 50; s++) begin
      if ($urandom_range(3) == 0) add_cmd(4'(($urandom_range(11)) + 4), $urandom_range(4095));
      case ($urandom_range(3))
        0: add_raw(0, 30'($urandom));
        1: add_pix(0);
        default: ;
      endcase
      if ($urandom_range(1) == 0) add_raw($urandom_range(16, 1), 30'($urandom));
      else add_pix($urandom_range(16, 1));
    end
    rst_n = 1'b1;
    run_expected();

    do_reset();
    clear_prog();
    add_pix(2);
    pix_hold = 1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pop_once();
    chk(out_word == IDLE_W, "R8", 32'(out_word), 32'(IDLE_W));
    chk(underflow == 1'b1, "R8", 32'(underflow), 32'd1);
    chk(pidx == 0, "R5", 32'(pidx), 32'd0);
    pix_hold = 0;
    for (int k = 0; k < 2; k++) begin
      repeat (3) @(negedge clk);
      pop_once();
      chk(out_word == exp_mem[k], "R5", 32'(out_word), 32'(exp_mem[k]));
    end
    chk(pidx == 2, "R5", 32'(pidx), 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule